// File: doc/BRIEF.md
# Parallel Port Control Register

This block holds the host-writable control byte of a PC-style parallel printer port. One bit selects the printer through an inverted output pin. One bit enables an interrupt that fires on a rising edge of the peripheral acknowledge line. One bit requests the data-path direction. The direction the port actually uses also depends on a 3-bit mode field supplied by the extended control logic: two modes force the port to output whatever the stored bit holds.

The host writes the register with `wr_en` and reads it with `rd_en`. Read data is registered and appears on the cycle after the read strobe. The acknowledge pin is asynchronous. It passes through a two-flop synchroniser, and a synchronised low-to-high transition latches an interrupt request when the enable bit is set. The request holds until the host reads the register.

Top module: `pport_ctl`

## Requirements
- R1: After reset, `rd_data` reads 0x00, `slct_in_n` is 1, `dir_in` is 0 and `irq` is 0.
- R2: On the edge that accepts a write, `slct_in_n` takes the inverse of written bit 3. Bit 3 = 1 drives the pin low, which selects the printer.
- R3: Bits 7:6 of `rd_data` always read 0, whatever was written to them.
- R4: Bits 5:0 read back exactly as last written. Bit 0 is the LSB. Bit 5 reads back its stored value even in modes that override the direction.
- R5: When `port_mode` is 3'b000 or 3'b010, `dir_in` is 0 (output) one cycle later, whatever bit 5 holds.
- R6: In all other modes, `dir_in` follows stored bit 5 one cycle later. 1 means input (read from the peripheral) and 0 means output.
- R7: When bit 4 is 1, a low-to-high transition on `ack_n_pin` raises `irq` on the third rising clock edge after the pin changes: two synchroniser stages, then the latch.
- R8: A rising edge on `ack_n_pin` while bit 4 is 0 does not raise `irq`, and a falling edge never raises it.
- R9: Once raised, `irq` stays 1 until a read strobe. The edge that takes the read clears it, unless a new qualified edge arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; also clears the interrupt |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| port_mode | input | 3 | Port mode from the extended control register |
| ack_n_pin | input | 1 | Asynchronous peripheral acknowledge pin, active low |
| slct_in_n | output | 1 | Printer-select pin level, active low |
| dir_in | output | 1 | Effective direction: 1 = input, 0 = output |
| irq | output | 1 | Latched acknowledge interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 3-bit mode field and two synchroniser stages. These sizes are small enough to sweep all 64 values of the stored bits against all 8 modes, with the reserved bits forced high on every write. That exposes every pairing of direction bit and mode override and every readback pattern. With two stages, the interrupt latency is a fixed three edges, which the bench checks both just before and at the edge where `irq` rises.

// File: rtl/pport_ctl_pkg.sv
package pport_ctl_pkg;
  localparam int DATA_W      = 8;
  localparam int MODE_W      = 3;
  localparam int STORE_W     = 6;
  localparam int POS_SEL     = 3;
  localparam int POS_IRQ_EN  = 4;
  localparam int POS_DIR     = 5;
  localparam logic [MODE_W-1:0] MODE_COMPAT = 3'b000;
  localparam logic [MODE_W-1:0] MODE_FWD_FIFO = 3'b010;
endpackage

// File: rtl/pport_ack_sync.sv
module pport_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sq[0] <= 1'b1;
          else     sq[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sq[i] <= 1'b1;
          else     sq[i] <= sq[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sq[STAGES-1];
  end

  assign rise = sq[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pport_ctl_store.sv
module pport_ctl_store
  import pport_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [STORE_W-1:0] ctl_q,
  output logic [DATA_W-1:0]  rd_data,
  output logic               slct_in_n
);
  localparam int PAD_W = DATA_W - STORE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      slct_in_n <= 1'b1;
    end else if (wr_en) begin
      ctl_q     <= wr_data[STORE_W-1:0];
      slct_in_n <= ~wr_data[POS_SEL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= {{PAD_W{1'b0}}, ctl_q};
  end

  assert_sel_pin_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (slct_in_n == ~$past(wr_data[POS_SEL])));
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data[DATA_W-1:STORE_W] == '0));
  assert_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en ##1 rd_en && !wr_en) |=> (rd_data[STORE_W-1:0] == $past(wr_data[STORE_W-1:0], 2)));
endmodule

// File: rtl/pport_dir_sel.sv
module pport_dir_sel
  import pport_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              dir_bit,
  output logic              dir_in
);
  logic forced_out;

  assign forced_out = (mode == MODE_COMPAT) || (mode == MODE_FWD_FIFO);

  always_ff @(posedge clk) begin
    if (rst) dir_in <= 1'b0;
    else     dir_in <= dir_bit & ~forced_out;
  end

  assert_forced_out_R5: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'b000) || (mode == 3'b010)) |=> !dir_in);
  assert_dir_follow_R6: assert property (@(posedge clk) disable iff (rst)
    ((mode != 3'b000) && (mode != 3'b010)) |=> (dir_in == $past(dir_bit)));
endmodule

// File: rtl/pport_irq_latch.sv
module pport_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  input  logic enable,
  input  logic clear,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)                    irq <= 1'b0;
    else if (edge_seen && enable) irq <= 1'b1;
    else if (clear)             irq <= 1'b0;
  end

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(enable));
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (irq && !clear) |=> irq);
endmodule

// File: rtl/pport_ctl.sv
module pport_ctl
  import pport_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [MODE_W-1:0] port_mode,
  input  logic              ack_n_pin,
  output logic              slct_in_n,
  output logic              dir_in,
  output logic              irq
);
  logic [STORE_W-1:0] ctl_q;
  logic               ack_rise;

  pport_ctl_store u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .ctl_q(ctl_q), .rd_data(rd_data), .slct_in_n(slct_in_n)
  );

  pport_dir_sel u_dir (
    .clk(clk), .rst(rst), .mode(port_mode), .dir_bit(ctl_q[POS_DIR]), .dir_in(dir_in)
  );

  pport_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(ack_n_pin), .rise(ack_rise)
  );

  pport_irq_latch u_irq (
    .clk(clk), .rst(rst), .edge_seen(ack_rise), .enable(ctl_q[POS_IRQ_EN]),
    .clear(rd_en), .irq(irq)
  );

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!irq && slct_in_n && !dir_in && rd_data == '0));
endmodule

// File: tb/pport_ctl_tb.sv
module pport_ctl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [2:0] port_mode = 3'b000;
  logic       ack_n_pin = 1'b1;
  logic       slct_in_n;
  logic       dir_in;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pport_ctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .port_mode(port_mode), .ack_n_pin(ack_n_pin),
    .slct_in_n(slct_in_n), .dir_in(dir_in), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] r;
    logic       exp_dir;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 slct_in_n", {7'd0, slct_in_n}, 8'h01);
    chk("R1 dir_in", {7'd0, dir_in}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(r);
    chk("R1 readback", r, 8'h00);

    // Sweep modes and stored patterns; reserved bits always written as 1
    for (int m = 0; m < 8; m++) begin
      for (int v = 0; v < 64; v++) begin
        port_mode = m[2:0];
        wr(8'hC0 | v[7:0]);
        // R2 select pin updated on the write edge
        chk("R2 slct_in_n", {7'd0, slct_in_n}, {7'd0, ~v[3]});
        @(negedge clk);
        exp_dir = ((m != 0) && (m != 2)) ? v[5] : 1'b0;
        if (m == 0 || m == 2) chk("R5 dir forced out", {7'd0, dir_in}, {7'd0, exp_dir});
        else                  chk("R6 dir follows bit", {7'd0, dir_in}, {7'd0, exp_dir});
        rd(r);
        chk("R3 reserved bits", {6'd0, r[7:6]}, 8'h00);
        chk("R4 readback", {2'd0, r[5:0]}, v[7:0]);
      end
    end

    // R7 qualified rising edge raises irq on third edge
    port_mode = 3'b001;
    wr(8'h10);
    rd(r);
    ack_n_pin = 1'b0; idle(4);
    chk("R8 falling edge no irq", {7'd0, irq}, 8'h00);
    ack_n_pin = 1'b1;
    idle(2);
    chk("R7 irq not before third edge", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R7 irq raised", {7'd0, irq}, 8'h01);
    idle(6);
    chk("R9 irq held", {7'd0, irq}, 8'h01);
    rd(r);
    chk("R9 irq cleared by read", {7'd0, irq}, 8'h00);
    chk("R4 readback after irq", r, 8'h10);

    // R8 disabled: rising edge ignored
    wr(8'h00);
    ack_n_pin = 1'b0; idle(4);
    ack_n_pin = 1'b1; idle(6);
    chk("R8 disabled edge", {7'd0, irq}, 8'h00);

    // R9 set wins over simultaneous read: edge reaches latch while reading
    wr(8'h10);
    ack_n_pin = 1'b0; idle(4);
    ack_n_pin = 1'b1; idle(2);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R9 set beats clear", {7'd0, irq}, 8'h01);
    rd(r);
    chk("R9 clear after", {7'd0, irq}, 8'h00);

    // R1 reset again clears everything
    wr(8'h3F);
    idle(1);
    rst = 1'b1; idle(2); rst = 1'b0;
    chk("R1 slct after reset", {7'd0, slct_in_n}, 8'h01);
    chk("R1 dir after reset", {7'd0, dir_in}, 8'h00);
    rd(r);
    chk("R1 readback after reset", r, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule